// File: doc/BRIEF.md
# Configuration Source Selector for a Data Converter

This block decides, for a data converter, whether its operating settings follow a set of static control pins or a small bank of registers written over a four-wire serial port. An active-low mode input picks the source. With the mode input high the block is in pin mode. A range pin then sets one full-scale code that both channels share. A phase pin sets the output clock phase, but only when the output is demultiplexed. The serial port stays disabled in this mode, and every register is held at its default.

With the mode input low the block is in register mode and the static pins are ignored. Each channel then takes its range code from its own register, and the clock phase takes its value from one bit of a control register. Software reaches the registers with 24-bit serial frames that can write or read. The mode input and all serial inputs are brought onto the system clock through a two-stage synchronizer. For that reason the serial clock must run well below the system clock, with each level held for at least four system clocks.

Top module: `cfg_source_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to pin mode, all registers go to their defaults and `ser_dout_oe` is low.
- R2: In pin mode, `range_pin` high gives code 0 (the smallest range) on both `range_i_code` and `range_q_code`. `range_pin` low gives the all-ones code on both.
- R3: In pin mode, `phase_out` follows `phase_pin` (0 = 0°, 1 = 90°) while `demux_off_pin` is low. It is 0 while `demux_off_pin` is high.
- R4: In register mode, `range_i_code` is the low FSR_W bits of register 03h, `range_q_code` is the low FSR_W bits of register 0Bh and `phase_out` is bit 14 of register 00h. None of the three static pins has any effect on these outputs.
- R5: A frame is sent MSB first and sampled on rising serial clock edges. Bit 23 selects read (1) or write (0), bits 22..16 hold the address and bits 15..0 hold the data.
- R6: A write frame updates its register when `ser_cs_n` rises after exactly 24 rising serial clock edges. A frame with 23 or 25 edges changes no register.
- R7: In a read frame, the 16 data bits of the addressed register come out on `ser_dout` MSB first, each one changed on a falling serial clock edge. The first bit appears on the falling edge that follows the 8th rising edge. Addresses other than 00h, 03h and 0Bh read as 0.
- R8: `ser_dout_oe` is high only in register mode with `ser_cs_n` low. Serial clock and data activity while `ser_cs_n` is high does not change any register.
- R9: A frame sent in pin mode changes no register. Raising `ext_ctl_n` returns every register to its default, so register mode starts again from defaults.
- R10: All registers default to 0, so register mode comes up with the smallest range on both channels and a 0° phase.
- R11: A change on `ext_ctl_n` reaches the outputs two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_ctl_n | input | 1 | Low selects register mode, high selects pin mode |
| range_pin | input | 1 | Pin-mode full-scale select for both channels |
| phase_pin | input | 1 | Pin-mode clock phase select (0°/90°) |
| demux_off_pin | input | 1 | High means non-demultiplexed output; phase pin then inactive |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial read data out |
| ser_dout_oe | output | 1 | Drive enable for `ser_dout`; low means high-impedance |
| range_i_code | output | FSR_W | Effective I-channel range code |
| range_q_code | output | FSR_W | Effective Q-channel range code |
| phase_out | output | 1 | Effective clock phase, 1 = 90° |

## Verification
The outputs are tried in pin mode with both range levels and all four combinations of phase pin and demux pin. Then the pins are swept again in register mode, which separates pin-driven outputs from register-driven ones. Writes to distinct patterns in each channel's register, followed by read-back, show that the I and Q registers are not swapped and that the address decode is correct. Frames of 23, 24 and 25 bits, a frame sent in pin mode and clock activity with chip select high are told apart by whether a later read returns the old value. A return to pin mode followed by re-entry into register mode shows that the defaults are restored.

// File: rtl/cfg_sel_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the configuration source selector.
// Assumes a fixed 24-bit frame of one direction bit, a 7-bit address and a
// 16-bit data word; register locations are part of the software contract.
package cfg_sel_pkg;
    localparam int FRAME_LEN = 24;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 16;
    localparam int HDR_LEN   = ADDR_W + 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam int CNT_SAT   = FRAME_LEN + 1;
    localparam int N_REGS    = 3;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_RNG_I = 1;
    localparam int IDX_RNG_Q = 2;
    localparam int PHASE_BIT = 14;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t REG_ADDR [N_REGS] = '{7'h00, 7'h03, 7'h0B};
    localparam word_t REG_DFLT [N_REGS] = '{16'h0000, 16'h0000, 16'h0000};
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchronizer for a bundle of asynchronous inputs.
// Assumes every bit is an independent level that stays stable for several
// clocks; each bit has its own reset value so that idle levels load on reset.
module cfg_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two flops in series per bit, loaded with the idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
// Module: serial frame engine. Detects serial clock and chip-select edges on
// already synchronized inputs, shifts in a frame, raises a one-cycle write
// strobe on a clean 24-bit frame and shifts read data out on falling edges.
// Assumes each serial clock level lasts at least four system clocks.
module cfg_serial_port
    import cfg_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  port_en,
    input  logic  cs_s,
    input  logic  sclk_s,
    input  logic  din_s,
    input  word_t rd_data,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  dout,
    output logic  dout_oe
);
    logic                 sclk_q;
    logic                 cs_q;
    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 load_pend;
    logic                 rd_act;
    word_t                shadow;
    logic                 sclk_rise;
    logic                 sclk_fall;
    logic                 cs_rise;
    logic                 idle;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = cs_s & ~cs_q;
    assign idle      = !port_en || cs_s;

    // Edge history of the synchronized serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    // Shift register and saturating bit counter for the incoming frame.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            load_pend <= 1'b0;
        end else if (sclk_rise) begin
            if (bit_cnt < CNT_W'(FRAME_LEN))
                shreg <= {shreg[FRAME_LEN-2:0], din_s};
            if (bit_cnt != CNT_W'(CNT_SAT))
                bit_cnt <= bit_cnt + 1'b1;
            load_pend <= (bit_cnt == CNT_W'(HDR_LEN - 1));
        end else begin
            load_pend <= 1'b0;
        end
    end

    // Read shadow: loaded once the header is in, shifted out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            rd_act <= 1'b0;
            shadow <= '0;
            dout   <= 1'b0;
        end else if (load_pend) begin
            rd_act <= shreg[HDR_LEN-1];
            shadow <= shreg[HDR_LEN-1] ? rd_data : '0;
        end else if (sclk_fall && rd_act) begin
            dout   <= shadow[DATA_W-1];
            shadow <= {shadow[DATA_W-2:0], 1'b0};
        end
    end

    assign rd_addr = shreg[ADDR_W-1:0];
    assign wr_addr = shreg[FRAME_LEN-2 -: ADDR_W];
    assign wr_data = shreg[DATA_W-1:0];
    assign wr_en   = port_en && cs_rise && (bit_cnt == CNT_W'(FRAME_LEN))
                     && !shreg[FRAME_LEN-1];
    assign dout_oe = port_en && !cs_s;
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
// Module: configuration register bank. One register per entry of the
// package address list, each forced to its default while hold_dflt is high.
// Assumes at most one write strobe per cycle; unmapped reads return zero.
module cfg_regfile
    import cfg_sel_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold_dflt,
    input  logic                          wr_en,
    input  addr_t                         wr_addr,
    input  word_t                         wr_data,
    input  addr_t                         rd_addr,
    output word_t                         rd_data,
    output logic [N_REGS-1:0][DATA_W-1:0] regs_o
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        word_t q;

        // One register: default while held, else take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || hold_dflt)
                q <= REG_DFLT[g];
            else if (wr_en && wr_addr == REG_ADDR[g])
                q <= wr_data;
        end

        assign regs_o[g] = q;
    end

    // Read mux over the mapped addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_REGS; i++)
            if (rd_addr == REG_ADDR[i])
                rd_data = regs_o[i];
    end
endmodule

// File: rtl/cfg_out_select.sv
`timescale 1ns/1ps
// Module: output selector. Picks pin-derived or register-derived settings.
// Assumes the mode bit is already synchronized; the static pins may feed
// straight through because they only matter in pin mode.
module cfg_out_select
    import cfg_sel_pkg::*;
#(
    parameter int FSR_W = 8
) (
    input  logic             pin_mode,
    input  logic             range_pin,
    input  logic             phase_pin,
    input  logic             demux_off_pin,
    input  word_t            reg_ctrl,
    input  word_t            reg_rng_i,
    input  word_t            reg_rng_q,
    output logic [FSR_W-1:0] range_i_code,
    output logic [FSR_W-1:0] range_q_code,
    output logic             phase_out
);
    localparam logic [FSR_W-1:0] CODE_MIN = '0;
    localparam logic [FSR_W-1:0] CODE_MAX = '1;

    logic [FSR_W-1:0] pin_code;

    // Pin-mode range: high pin selects the smallest register-mode range.
    assign pin_code = range_pin ? CODE_MIN : CODE_MAX;

    // Source selection for both channels and the phase.
    always_comb begin
        if (pin_mode) begin
            range_i_code = pin_code;
            range_q_code = pin_code;
            phase_out    = phase_pin && !demux_off_pin;
        end else begin
            range_i_code = reg_rng_i[FSR_W-1:0];
            range_q_code = reg_rng_q[FSR_W-1:0];
            phase_out    = reg_ctrl[PHASE_BIT];
        end
    end
endmodule

// File: rtl/cfg_source_sel.sv
`timescale 1ns/1ps
// Module: top of the configuration source selector. Synchronizes the mode
// and serial inputs, runs the serial frame engine and register bank, and
// selects the effective range codes and phase. Assumes FSR_W <= 16.
module cfg_source_sel
    import cfg_sel_pkg::*;
#(
    parameter int FSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_ctl_n,
    input  logic             range_pin,
    input  logic             phase_pin,
    input  logic             demux_off_pin,
    input  logic             ser_cs_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    output logic             ser_dout,
    output logic             ser_dout_oe,
    output logic [FSR_W-1:0] range_i_code,
    output logic [FSR_W-1:0] range_q_code,
    output logic             phase_out
);
    logic                          ext_s;
    logic                          cs_s;
    logic                          sclk_s;
    logic                          din_s;
    logic                          wr_en;
    addr_t                         wr_addr;
    word_t                         wr_data;
    addr_t                         rd_addr;
    word_t                         rd_data;
    logic [N_REGS-1:0][DATA_W-1:0] regs;

    cfg_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_ctl_n, ser_cs_n, ser_clk, ser_din}),
        .q     ({ext_s, cs_s, sclk_s, din_s})
    );

    cfg_serial_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (!ext_s),
        .cs_s    (cs_s),
        .sclk_s  (sclk_s),
        .din_s   (din_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (ser_dout),
        .dout_oe (ser_dout_oe)
    );

    cfg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_dflt (ext_s),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_o    (regs)
    );

    cfg_out_select #(.FSR_W(FSR_W)) u_sel (
        .pin_mode      (ext_s),
        .range_pin     (range_pin),
        .phase_pin     (phase_pin),
        .demux_off_pin (demux_off_pin),
        .reg_ctrl      (regs[IDX_CTRL]),
        .reg_rng_i     (regs[IDX_RNG_I]),
        .reg_rng_q     (regs[IDX_RNG_Q]),
        .range_i_code  (range_i_code),
        .range_q_code  (range_q_code),
        .phase_out     (phase_out)
    );
endmodule

// File: rtl/cfg_source_sel_chk.sv
`timescale 1ns/1ps
// Module: property checker for the configuration source selector, attached
// to the top by bind. Observes synchronized mode, write strobe and registers.
module cfg_source_sel_chk
    import cfg_sel_pkg::*;
#(
    parameter int FSR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          pin_mode,
    input logic                          cs_s,
    input logic                          wr_en,
    input logic                          demux_off_pin,
    input logic                          dout_oe,
    input logic [FSR_W-1:0]              range_i_code,
    input logic [FSR_W-1:0]              range_q_code,
    input logic                          phase_out,
    input logic [N_REGS-1:0][DATA_W-1:0] regs
);
    // R2: one shared range in pin mode.
    p_pin_shared_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |-> (range_i_code == range_q_code));

    // R3: phase pin inactive without demux.
    p_phase_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && demux_off_pin) |-> !phase_out);

    // R4: in register mode outputs move only after a write.
    p_pins_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && !$past(pin_mode) && !$past(wr_en)) |->
        ($stable(range_i_code) && $stable(range_q_code) && $stable(phase_out)));

    // R6: a register changes in register mode only after a write strobe.
    p_change_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs != $past(regs)) && !$past(pin_mode)) |-> $past(wr_en));

    // R8: output drive only in register mode with chip select low.
    p_dout_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode || cs_s) |-> !dout_oe);

    // R9: pin mode forces defaults on the next edge.
    p_regs_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |=> (regs == '0));
endmodule

bind cfg_source_sel cfg_source_sel_chk #(.FSR_W(FSR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_mode      (ext_s),
    .cs_s          (cs_s),
    .wr_en         (wr_en),
    .demux_off_pin (demux_off_pin),
    .dout_oe       (ser_dout_oe),
    .range_i_code  (range_i_code),
    .range_q_code  (range_q_code),
    .phase_out     (phase_out),
    .regs          (regs)
);

// File: tb/cfg_source_sel_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped every clock and compared with
// the outputs at each falling edge; frames are driven by tasks.
module cfg_source_sel_tb_top;
    localparam int FSR_W = 8;
    localparam int CMAX  = (1 << FSR_W) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, ext_ctl_n = 1'b1, range_pin = 1'b1, phase_pin = 1'b0;
    logic demux_off_pin = 1'b0, ser_cs_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic ser_dout, ser_dout_oe, phase_out;
    logic [FSR_W-1:0] range_i_code, range_q_code;

    cfg_source_sel #(.FSR_W(FSR_W)) dut_i (.*);

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // Reference model: delayed views of the mode and chip select, registers.
    int m_ext1 = 1, m_ext2 = 1, m_cs1 = 1, m_cs2 = 1, m_csq = 1;
    int m_reg [int];
    logic [23:0] m_pend_word = '0;
    int m_pend_bits = 0;

    task automatic check_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int reg_of(int a);
        return m_reg.exists(a) ? m_reg[a] : 0;
    endfunction

    task automatic reset_model_regs();
        m_reg.delete();
        m_reg[0] = 0; m_reg[3] = 0; m_reg[11] = 0;
    endtask

    task automatic compare_outputs();
        int ei, eq, ep, eo;
        if (m_ext2 != 0) begin
            ei = range_pin ? 0 : CMAX;
            eq = ei;
            ep = demux_off_pin ? 0 : int'(phase_pin);
        end else begin
            ei = reg_of(3) & CMAX;
            eq = reg_of(11) & CMAX;
            ep = (reg_of(0) >> 14) & 1;
        end
        eo = (m_cs2 == 0 && m_ext2 == 0) ? 1 : 0;
        check_val(cur_req, "range_i_code", int'(range_i_code), ei);
        check_val(cur_req, "range_q_code", int'(range_q_code), eq);
        check_val(cur_req, "phase_out", int'(phase_out), ep);
        check_val(cur_req, "ser_dout_oe", int'(ser_dout_oe), eo);
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_ext1 = 1; m_ext2 = 1; m_cs1 = 1; m_cs2 = 1; m_csq = 1;
            reset_model_regs();
        end else begin
            if (m_ext2 != 0) reset_model_regs();
            else if (m_cs2 != 0 && m_csq == 0 && m_pend_bits == 24 && !m_pend_word[23]) begin
                int a = int'(m_pend_word[22:16]);
                if (a == 0 || a == 3 || a == 11) m_reg[a] = int'(m_pend_word[15:0]);
            end
            m_csq = m_cs2; m_cs2 = m_cs1; m_cs1 = int'(ser_cs_n);
            m_ext2 = m_ext1; m_ext1 = int'(ext_ctl_n);
        end
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic frame(input logic [23:0] w, input int nbits, output logic [15:0] rd);
        rd = '0;
        ser_cs_n = 1'b0;
        ticks(4);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 24) ? w[23-i] : 1'b0;
            ser_clk = 1'b0;
            ticks(4);
            if (i >= 8 && i < 24) rd[23-i] = ser_dout;
            ser_clk = 1'b1;
            ticks(4);
        end
        ser_clk = 1'b0;
        ticks(4);
        m_pend_word = w;
        m_pend_bits = nbits;
        ser_cs_n = 1'b1;
        ticks(6);
        m_pend_bits = 0;
        ser_din = 1'b0;
    endtask

    task automatic wr(int a, int d, int nbits);
        logic [15:0] rd;
        frame({1'b0, 7'(a), 16'(d)}, nbits, rd);
    endtask

    task automatic rd_check(string req, int a);
        logic [15:0] rd;
        frame({1'b1, 7'(a), 16'h0000}, 24, rd);
        check_val(req, $sformatf("read addr %0h", a), int'(rd), reg_of(a));
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        reset_model_regs();
        @(negedge clk);
        cur_req = "R1";
        ticks(3);
        check_val("R1", "oe in reset", int'(ser_dout_oe), 0);
        rst_n = 1'b1;
        ticks(3);

        cur_req = "R2";
        range_pin = 1'b0; ticks(2);
        check_val("R2", "pin low code", int'(range_q_code), CMAX);
        range_pin = 1'b1; ticks(2);
        check_val("R2", "pin high code", int'(range_i_code), 0);

        cur_req = "R3";
        phase_pin = 1'b1; demux_off_pin = 1'b0; ticks(2);
        check_val("R3", "phase demux on", int'(phase_out), 1);
        demux_off_pin = 1'b1; ticks(2);
        check_val("R3", "phase demux off", int'(phase_out), 0);
        phase_pin = 1'b0; ticks(2);
        demux_off_pin = 1'b0; ticks(2);

        cur_req = "R9";
        wr(3, 16'h0055, 24);

        cur_req = "R11";
        range_pin = 1'b0;
        ext_ctl_n = 1'b0;
        tick();
        check_val("R11", "mode after one edge", int'(range_i_code), CMAX);
        tick();
        check_val("R11", "mode after two edges", int'(range_i_code), 0);
        cur_req = "R10";
        ticks(2);
        check_val("R10", "default phase", int'(phase_out), 0);

        cur_req = "R4";
        phase_pin = 1'b1; ticks(3);
        demux_off_pin = 1'b1; range_pin = 1'b1; ticks(3);
        check_val("R4", "pins ignored", int'(range_q_code), 0);

        cur_req = "R5";
        wr(3, 16'h00A7, 24);
        wr(11, 16'h0013, 24);
        wr(0, 16'h4000, 24);
        check_val("R5", "I code", int'(range_i_code), 8'hA7);
        check_val("R5", "Q code", int'(range_q_code), 8'h13);
        check_val("R5", "phase bit", int'(phase_out), 1);

        cur_req = "R7";
        rd_check("R7", 3);
        rd_check("R7", 11);
        rd_check("R7", 0);
        rd_check("R7", 5);

        cur_req = "R6";
        wr(3, 16'h00FF, 23);
        wr(11, 16'h00FF, 25);
        rd_check("R6", 3);
        rd_check("R6", 11);

        cur_req = "R8";
        for (int k = 0; k < 30; k++) begin
            ser_clk = ~ser_clk; ser_din = ~ser_din;
            ticks(4);
        end
        ser_clk = 1'b0; ser_din = 1'b0; ticks(4);
        rd_check("R8", 3);

        cur_req = "R9";
        ext_ctl_n = 1'b1; ticks(4);
        ext_ctl_n = 1'b0; ticks(4);
        rd_check("R9", 3);
        rd_check("R9", 0);
        check_val("R9", "phase after re-entry", int'(phase_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule